// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer

This block keeps a 64-word, 16-bit history of program flow for debug. It is armed by software and starts recording once an external trigger comparator fires. The CPU supplies one bus event per cycle, already classified. Each event has a kind, a cycle type, an address, a data value and a flag that marks excluded interrupt vectors. The capture mode decides which events become entries. Normal mode keeps change-of-flow addresses. Loop-suppressed mode does the same but drops repeats of the last stored address. Detail mode keeps address and data pairs for data cycles. Profile mode stores nothing. Instead, the read port shows the address of the instruction that completed last.

In the non-detail modes a second option stores data values on event-only comparator matches instead of flow addresses. Software reads the history after disarming. A read pointer auto-increments, starts at the oldest surviving entry and steps through the buffer one entry per read strobe.

Top module: `cof_trace_buf`

## Requirements
- R1: After reset, count_o is 0 and full_o is 0.
- R2: In mode 0 (normal), once capture is running, an event is stored as its address only when its kind is one of the following: 1 (taken conditional branch source), 2 (indirect jump or call destination), 3 (return destination) or 4 (interrupt vector). Kinds 0 and 5 are not stored.
- R3: A kind-4 event with ev_vec_excl_i high is not stored. The flag has no effect on other kinds.
- R4: In mode 1 (loop-suppressed), the mode-0 filter applies, and an address equal to the last address stored since arming is not stored. The comparator reloads with every stored address.
- R5: In mode 2 (detail), an event with cycle type 2 (read) or 3 (write) stores two consecutive entries, address first and then data. Cycle types 0 (program fetch) and 1 (free) store nothing.
- R6: With evb_mode_i high in mode 0 or 1, each cycle with evb_hit_i stores ev_data_i. Change-of-flow events are then not stored.
- R7: The write position wraps from 63 to 0. count_o saturates at 64, and full_o is high exactly when count_o is 64.
- R8: A rising edge of arm_i clears the count, the write position, the read offset, the trigger-seen state and the loop comparator.
- R9: With arm_i low, rd_data_o shows the entry at the oldest position plus the read offset. The oldest position is 0 when the buffer is not full and the write position when it is full. Each rd_i cycle advances the offset by one, modulo 64.
- R10: With arm_i high outside mode 3, rd_data_o is 0 and rd_i has no effect on the read offset.
- R11: In mode 3 (profile), nothing is stored. rd_data_o shows the inst_pc_i value of the last cycle with inst_done_i, whether or not the block is armed, and rd_i does not move the read offset.
- R12: Capture runs only while arm_i is high, from the cycle in which trig_i is first seen high after arming. An event in that same cycle is stored. Events before it are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Capture mode: 0 normal, 1 loop-suppressed, 2 detail, 3 profile |
| arm_i | input | 1 | Capture armed; a rising edge restarts the buffer |
| trig_i | input | 1 | Trigger from the comparator logic |
| ev_valid_i | input | 1 | A bus event is present this cycle |
| ev_kind_i | input | 3 | Event kind (see R2) |
| ev_cyc_i | input | 2 | Bus cycle type (see R5) |
| ev_vec_excl_i | input | 1 | Vector belongs to an excluded interrupt source |
| ev_addr_i | input | 16 | Event address |
| ev_data_i | input | 16 | Event data |
| evb_mode_i | input | 1 | Event-only data storing selected |
| evb_hit_i | input | 1 | Event-only comparator match this cycle |
| inst_done_i | input | 1 | An instruction completed this cycle |
| inst_pc_i | input | 16 | Address of the completed instruction |
| rd_i | input | 1 | Read strobe, advances the read offset |
| rd_data_o | output | 16 | Read data |
| count_o | output | 7 | Number of valid entries, 0 to 64 |
| full_o | output | 1 | Buffer holds 64 entries |

## Verification
The trigger and the first qualifying event can fall in the same cycle. The bench drives trig_i together with an indirect-jump event right after arming, with an earlier event sent before the trigger. It then reads back and checks that the same-cycle address is the oldest entry and that the earlier one is missing. The re-arm edge and the loop comparator reload also meet in one cycle. After re-arming, an address that matches the old comparator contents must be stored once a new trigger arrives.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  typedef enum logic [1:0] {
    MODE_COF     = 2'd0,
    MODE_LOOP    = 2'd1,
    MODE_DETAIL  = 2'd2,
    MODE_PROFILE = 2'd3
  } cap_mode_e;

  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_BR_TAKEN = 3'd1,
    EV_IND_JUMP = 3'd2,
    EV_RETURN   = 3'd3,
    EV_VECTOR   = 3'd4,
    EV_DATA     = 3'd5
  } ev_kind_e;

  typedef enum logic [1:0] {
    CY_PFETCH = 2'd0,
    CY_FREE   = 2'd1,
    CY_READ   = 2'd2,
    CY_WRITE  = 2'd3
  } cyc_e;
endpackage

// File: rtl/ctb_filter.sv
module ctb_filter
  import ctb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_en_i,
  input  cap_mode_e     mode_i,
  input  logic          ev_valid_i,
  input  ev_kind_e      kind_i,
  input  cyc_e          cyc_i,
  input  logic          vec_excl_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          evb_mode_i,
  input  logic          evb_hit_i,
  output logic          wr0_o,
  output logic          wr1_o,
  output logic [DW-1:0] wr0_d_o,
  output logic [DW-1:0] wr1_d_o
);
  logic [DW-1:0] cmp_q;
  logic          cmp_v_q;
  logic          is_cof, loop_hit, data_cyc;
  logic          wr0_raw, wr1_raw, cof_path;

  always_comb begin
    unique case (kind_i)
      EV_BR_TAKEN, EV_IND_JUMP, EV_RETURN: is_cof = ev_valid_i;
      EV_VECTOR:                           is_cof = ev_valid_i & ~vec_excl_i;
      default:                             is_cof = 1'b0;
    endcase
  end

  // comparator is treated as empty in the re-arm cycle
  assign loop_hit = cmp_v_q & ~clr_i & (addr_i == cmp_q);
  assign data_cyc = ev_valid_i & ((cyc_i == CY_READ) | (cyc_i == CY_WRITE));

  always_comb begin
    wr0_raw  = 1'b0;
    wr1_raw  = 1'b0;
    wr0_d_o  = addr_i;
    wr1_d_o  = data_i;
    cof_path = 1'b0;
    unique case (mode_i)
      MODE_COF, MODE_LOOP: begin
        if (evb_mode_i) begin
          wr0_raw = evb_hit_i;
          wr0_d_o = data_i;
        end else begin
          cof_path = 1'b1;
          wr0_raw  = is_cof & ~((mode_i == MODE_LOOP) & loop_hit);
        end
      end
      MODE_DETAIL: begin
        wr0_raw = data_cyc;
        wr1_raw = data_cyc;
      end
      default: ;
    endcase
  end

  assign wr0_o = cap_en_i & wr0_raw;
  assign wr1_o = cap_en_i & wr1_raw;

  logic loop_store;
  assign loop_store = wr0_o & cof_path & (mode_i == MODE_LOOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= '0;
      cmp_v_q <= 1'b0;
    end else if (loop_store) begin
      cmp_q   <= addr_i;
      cmp_v_q <= 1'b1;
    end else if (clr_i) begin
      cmp_v_q <= 1'b0;
    end
  end

  AST_DETAIL_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr1_o |-> (wr0_o && mode_i == MODE_DETAIL)); // R5
  AST_LOOP_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_store && $past(loop_store) && !clr_i) |-> (addr_i != $past(addr_i))); // R4
endmodule

// File: rtl/ctb_store.sv
module ctb_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr0_i,
  input  logic          wr1_i,
  input  logic [DW-1:0] wr0_d_i,
  input  logic [DW-1:0] wr1_d_i,
  input  logic [PW-1:0] rd_off_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, base_ptr, ptr1, oldest;
  logic [CW-1:0] cnt_q, base_cnt;
  logic [CW:0]   sum;
  logic [1:0]    n_wr;

  assign base_ptr = clr_i ? '0 : wptr_q;
  assign base_cnt = clr_i ? '0 : cnt_q;
  assign ptr1     = base_ptr + PW'(1);
  assign n_wr     = {1'b0, wr0_i} + {1'b0, wr0_i & wr1_i};
  assign sum      = {1'b0, base_cnt} + (CW+1)'(n_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= base_ptr + PW'(n_wr);
      cnt_q  <= (sum > (CW+1)'(DEPTH)) ? CW'(DEPTH) : sum[CW-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr0_i) mem[base_ptr] <= wr0_d_i;
    if (wr0_i && wr1_i) mem[ptr1] <= wr1_d_i;
  end

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign oldest    = full_o ? wptr_q : '0;
  assign rd_data_o = mem[oldest + rd_off_i];
  assign count_o   = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R7
  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !clr_i) |=> full_o); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr0_i) |=> (count_o == '0)); // R8
endmodule

// File: rtl/ctb_reader.sv
module ctb_reader
  import ctb_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          arm_i,
  input  cap_mode_e     mode_i,
  input  logic          rd_i,
  input  logic          inst_done_i,
  input  logic [DW-1:0] inst_pc_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [PW-1:0] rd_off_o,
  output logic [DW-1:0] rd_data_o
);
  logic [PW-1:0] off_q;
  logic [DW-1:0] last_pc_q;
  logic          prof;

  assign prof = (mode_i == MODE_PROFILE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q     <= '0;
      last_pc_q <= '0;
    end else begin
      if (clr_i) off_q <= '0;
      else if (rd_i && !arm_i && !prof) off_q <= off_q + PW'(1);
      if (inst_done_i) last_pc_q <= inst_pc_i;
    end
  end

  assign rd_off_o  = off_q;
  assign rd_data_o = prof ? last_pc_q : (arm_i ? '0 : mem_data_i);

  AST_RD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !clr_i && !prof) |=> $stable(off_q)); // R10
  AST_PROF_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prof && !clr_i) |=> $stable(off_q)); // R11
endmodule

// File: rtl/cof_trace_buf.sv
module cof_trace_buf
  import ctb_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          arm_i,
  input  logic          trig_i,
  input  logic          ev_valid_i,
  input  logic [2:0]    ev_kind_i,
  input  logic [1:0]    ev_cyc_i,
  input  logic          ev_vec_excl_i,
  input  logic [DW-1:0] ev_addr_i,
  input  logic [DW-1:0] ev_data_i,
  input  logic          evb_mode_i,
  input  logic          evb_hit_i,
  input  logic          inst_done_i,
  input  logic [DW-1:0] inst_pc_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  cap_mode_e     mode;
  logic          arm_q, trig_seen_q, arm_rise, cap_en;
  logic          wr0, wr1;
  logic [DW-1:0] wr0_d, wr1_d, mem_data;
  logic [PW-1:0] rd_off;

  assign mode     = cap_mode_e'(mode_i);
  assign arm_rise = arm_i & ~arm_q;
  assign cap_en   = arm_i & (trig_i | (trig_seen_q & ~arm_rise));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q       <= 1'b0;
      trig_seen_q <= 1'b0;
    end else begin
      arm_q       <= arm_i;
      trig_seen_q <= arm_i & cap_en;
    end
  end

  ctb_filter #(.DW(DW)) u_filter (
    .clk_i, .rst_ni,
    .clr_i      (arm_rise),
    .cap_en_i   (cap_en),
    .mode_i     (mode),
    .ev_valid_i,
    .kind_i     (ev_kind_e'(ev_kind_i)),
    .cyc_i      (cyc_e'(ev_cyc_i)),
    .vec_excl_i (ev_vec_excl_i),
    .addr_i     (ev_addr_i),
    .data_i     (ev_data_i),
    .evb_mode_i,
    .evb_hit_i,
    .wr0_o      (wr0),
    .wr1_o      (wr1),
    .wr0_d_o    (wr0_d),
    .wr1_d_o    (wr1_d)
  );

  ctb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .clr_i     (arm_rise),
    .wr0_i     (wr0),
    .wr1_i     (wr1),
    .wr0_d_i   (wr0_d),
    .wr1_d_i   (wr1_d),
    .rd_off_i  (rd_off),
    .rd_data_o (mem_data),
    .count_o,
    .full_o
  );

  ctb_reader #(.DW(DW), .DEPTH(DEPTH)) u_reader (
    .clk_i, .rst_ni,
    .clr_i      (arm_rise),
    .arm_i,
    .mode_i     (mode),
    .rd_i,
    .inst_done_i,
    .inst_pc_i,
    .mem_data_i (mem_data),
    .rd_off_o   (rd_off),
    .rd_data_o
  );

  AST_NO_CAP_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |-> !wr0); // R12
  AST_PROF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_PROFILE) |-> !wr0); // R11
  AST_ARM_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_rise && !trig_i) |-> !wr0); // R8
endmodule

// File: tb/cof_trace_buf_tb_top.sv
module cof_trace_buf_tb_top;
  localparam time CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        arm_i = 1'b0, trig_i = 1'b0;
  logic        ev_valid_i = 1'b0;
  logic [2:0]  ev_kind_i = '0;
  logic [1:0]  ev_cyc_i = '0;
  logic        ev_vec_excl_i = 1'b0;
  logic [15:0] ev_addr_i = '0, ev_data_i = '0;
  logic        evb_mode_i = 1'b0, evb_hit_i = 1'b0;
  logic        inst_done_i = 1'b0;
  logic [15:0] inst_pc_i = '0;
  logic        rd_i = 1'b0;
  logic [15:0] rd_data_o;
  logic [6:0]  count_o;
  logic        full_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  cof_trace_buf dut_i (
    .clk_i(clk), .rst_ni, .mode_i, .arm_i, .trig_i, .ev_valid_i, .ev_kind_i,
    .ev_cyc_i, .ev_vec_excl_i, .ev_addr_i, .ev_data_i, .evb_mode_i, .evb_hit_i,
    .inst_done_i, .inst_pc_i, .rd_i, .rd_data_o, .count_o, .full_o
  );

  // kind, vec_excl, addr, expect_stored
  localparam logic [20:0] NVEC [0:7] = '{
    {3'd1, 1'b0, 16'h1000, 1'b1},
    {3'd2, 1'b0, 16'h2100, 1'b1},
    {3'd3, 1'b0, 16'h3200, 1'b1},
    {3'd4, 1'b0, 16'hFFF6, 1'b1},
    {3'd4, 1'b1, 16'hFFF8, 1'b0},
    {3'd5, 1'b0, 16'h4400, 1'b0},
    {3'd0, 1'b0, 16'h5500, 1'b0},
    {3'd1, 1'b1, 16'h6600, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input logic [2:0] k, input logic [1:0] cy,
                    input logic [15:0] a, input logic [15:0] d, input logic x);
    ev_valid_i = 1'b1; ev_kind_i = k; ev_cyc_i = cy;
    ev_addr_i = a; ev_data_i = d; ev_vec_excl_i = x;
    @(negedge clk);
    ev_valid_i = 1'b0; ev_vec_excl_i = 1'b0;
  endtask

  task automatic arm_trig(input logic [1:0] m);
    mode_i = m; arm_i = 1'b0;
    @(negedge clk);
    arm_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic read_check(input string req);
    arm_i = 1'b0;
    @(negedge clk);
    foreach (exp_q[i]) begin
      chk(req, rd_data_o, exp_q[i]);
      rd_i = 1'b1;
      @(negedge clk);
      rd_i = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 count", 16'(count_o), 16'd0);
    chk("R1 full", 16'(full_o), 16'd0);

    // R2 R3 R12: pre-trigger event dropped, same-cycle trigger event kept
    mode_i = 2'd0; arm_i = 1'b1;
    @(negedge clk);
    ev(3'd1, 2'd0, 16'h1111, 16'h0, 1'b0);
    chk("R12 pre-trigger", 16'(count_o), 16'd0);
    trig_i = 1'b1;
    ev(3'd2, 2'd0, 16'h2000, 16'h0, 1'b0);
    trig_i = 1'b0;
    exp_q = {16'h2000};
    for (int i = 0; i < 8; i++) begin
      ev(NVEC[i][20:18], 2'd0, NVEC[i][16:1], 16'h0, NVEC[i][17]);
      if (NVEC[i][0]) exp_q.push_back(NVEC[i][16:1]);
    end
    chk("R2 R3 count", 16'(count_o), 16'(exp_q.size()));
    chk("R10 armed read zero", rd_data_o, 16'h0);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    read_check("R2 R3 R9 R10 R12 contents");

    // R4 R8: loop suppression and comparator clear on re-arm
    arm_trig(2'd1);
    ev(3'd1, 2'd0, 16'h0A00, 16'h0, 1'b0);
    ev(3'd1, 2'd0, 16'h0A00, 16'h0, 1'b0);
    ev(3'd3, 2'd0, 16'h0B00, 16'h0, 1'b0);
    ev(3'd3, 2'd0, 16'h0B00, 16'h0, 1'b0);
    ev(3'd1, 2'd0, 16'h0A00, 16'h0, 1'b0);
    chk("R4 count", 16'(count_o), 16'd3);
    exp_q = {16'h0A00, 16'h0B00, 16'h0A00};
    read_check("R4 contents");
    arm_i = 1'b1;
    @(negedge clk);
    chk("R8 count cleared", 16'(count_o), 16'd0);
    ev(3'd1, 2'd0, 16'h0A00, 16'h0, 1'b0);
    chk("R8 trigger cleared", 16'(count_o), 16'd0);
    trig_i = 1'b1;
    ev(3'd1, 2'd0, 16'h0A00, 16'h0, 1'b0);
    trig_i = 1'b0;
    chk("R4 R8 comparator cleared", 16'(count_o), 16'd1);

    // R5: detail pairs
    arm_trig(2'd2);
    ev(3'd5, 2'd2, 16'h0100, 16'hAAAA, 1'b0);
    ev(3'd5, 2'd0, 16'h0200, 16'h1234, 1'b0);
    ev(3'd5, 2'd1, 16'h0300, 16'h4321, 1'b0);
    ev(3'd5, 2'd3, 16'h0102, 16'h5555, 1'b0);
    chk("R5 count", 16'(count_o), 16'd4);
    exp_q = {16'h0100, 16'hAAAA, 16'h0102, 16'h5555};
    read_check("R5 contents");

    // R6: event-only data
    evb_mode_i = 1'b1;
    arm_trig(2'd0);
    ev(3'd1, 2'd0, 16'h7000, 16'h1111, 1'b0);
    chk("R6 no cof", 16'(count_o), 16'd0);
    evb_hit_i = 1'b1;
    ev(3'd1, 2'd0, 16'h7100, 16'hBEEF, 1'b0);
    evb_hit_i = 1'b0;
    chk("R6 count", 16'(count_o), 16'd1);
    exp_q = {16'hBEEF};
    read_check("R6 contents");
    evb_mode_i = 1'b0;

    // R7 R9: wrap, saturation, oldest-first read
    arm_trig(2'd0);
    for (int i = 0; i < 63; i++) ev(3'd1, 2'd0, 16'h8000 + 16'(i), 16'h0, 1'b0);
    chk("R7 count 63", 16'(count_o), 16'd63);
    chk("R7 not full", 16'(full_o), 16'd0);
    ev(3'd1, 2'd0, 16'h803F, 16'h0, 1'b0);
    chk("R7 full", 16'(full_o), 16'd1);
    for (int i = 64; i < 70; i++) ev(3'd1, 2'd0, 16'h8000 + 16'(i), 16'h0, 1'b0);
    chk("R7 saturate", 16'(count_o), 16'd64);
    exp_q.delete();
    for (int i = 0; i < 65; i++) exp_q.push_back(16'h8006 + 16'(i % 64));
    read_check("R7 R9 wrap contents");

    // R11: profile
    mode_i = 2'd3; arm_i = 1'b1;
    @(negedge clk);
    inst_done_i = 1'b1; inst_pc_i = 16'h1234;
    @(negedge clk);
    inst_pc_i = 16'h5678;
    trig_i = 1'b1;
    ev(3'd1, 2'd0, 16'h9000, 16'h0, 1'b0);
    trig_i = 1'b0; inst_done_i = 1'b0;
    chk("R11 last pc", rd_data_o, 16'h5678);
    chk("R11 nothing stored", 16'(count_o), 16'd0);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    chk("R11 read holds", rd_data_o, 16'h5678);
    arm_i = 1'b0;
    @(negedge clk);
    chk("R11 unarmed", rd_data_o, 16'h5678);

    finish_run();
  end
endmodule